// File: doc/BRIEF.md
# Multi-Mode Timer Channel

One timer channel built from a prescaler, a 16-bit counter and a single I/O pin. A 3-bit mode field chooses what the channel does: nothing (the idle state that also acts as the restart), capturing the counter on pin edges, comparing the counter against a limit and toggling the pin, generating PWM, running as an internal timeout, or acting as plain GPIO. A single run-mode bit (stop or continuous) changes what happens at each event, and that meaning differs from mode to mode.

Software loads three values through simple write strobes that share one data bus: the prescale limit, the counter limit and the PWM width. It reads the last captured count on a dedicated output. Each capture, compare, PWM period wrap or timeout sets a sticky status flag. The flag is cleared only by passing through the idle mode. The interrupt line is that flag gated by an enable. An open-drain option turns every driven logic 1 into high impedance.

Top module: `tmr_channel`

## Requirements
- R1: Mode code 000 (idle) clears the prescaler, the counter, the stop latch, the compare output level and the status flag within one clock. In idle the pin is not driven (`pin_oe_o`=0).
- R2: The counter advances only on a prescaler tick. A tick occurs every (prescale+1) clocks while the channel runs, so with prescale 1 each counter step takes two clocks.
- R3: In capture mode (001) with the run bit at 0 (stop), a rising pin edge copies the counter to `capture_o`, sets status and clears the counter. With prescale 0 and rising edges N clocks apart, the captured value is N-1.
- R4: In capture mode with the run bit at 1 (continuous), a rising edge copies the counter but does not clear it. Successive captures then accumulate, and two edges N clocks apart (prescale 0) give captures that differ by N.
- R5: With `pulse_cap_i`=1 in capture mode, the run bit is ignored. A rising edge clears the counter, and a falling edge captures it, sets status and clears it again. A high phase sampled on H clocks (prescale 0) captures H-1.
- R6: In compare mode (010) with the run bit at 0, the first tick on which the counter is at or above the limit sets status, toggles the pin level and freezes the counter. Nothing changes after that until mode 000 has been applied.
- R7: In compare mode with the run bit at 1, the counter clears and keeps running at each match. The pin then toggles once every (limit+1) ticks.
- R8: In PWM mode (011) the pin is driven 1 while the counter is below the width and 0 otherwise. The period is limit+1 ticks, status is set at each period wrap, and the run bit has no effect.
- R9: In timer mode (100) an expiry (counter at or above the limit on a tick) sets status. With the run bit at 0 the channel then halts until mode 000. With the run bit at 1 it clears and restarts at once.
- R10: With `open_drain_i`=1, any logic 1 that compare, PWM or GPIO would drive is turned into `pin_oe_o`=0. A driven 0 is unaffected.
- R11: In timer mode (100) and GPIO-only mode (101), `gpio_sel_i` controls the pin: 0x means input (not driven), 10 drives 0, and 11 drives 1.
- R12: Status is sticky outside mode 000. `irq_o` equals status AND `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Mode: 000 idle, 001 capture, 010 compare, 011 PWM, 100 timer, 101 GPIO |
| cont_i | input | 1 | Run bit: 0 stop, 1 continuous |
| pulse_cap_i | input | 1 | Capture the width of the high phase instead of the edge-to-edge count |
| open_drain_i | input | 1 | Turn every driven 1 into high impedance |
| irq_en_i | input | 1 | Interrupt enable |
| gpio_sel_i | input | 2 | GPIO control: 0x input, 10 drive 0, 11 drive 1 |
| wr_prescale_i | input | 1 | Load the prescale limit from `wdata_i` |
| wr_limit_i | input | 1 | Load the counter limit from `wdata_i` |
| wr_width_i | input | 1 | Load the PWM width from `wdata_i` |
| wdata_i | input | 16 | Write data |
| pin_i | input | 1 | Pin input value |
| pin_o | output | 1 | Pin output value (0 when not driven) |
| pin_oe_o | output | 1 | Pin output enable |
| capture_o | output | 16 | Last captured counter value |
| status_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the frozen compare/timer state, and showing that only idle releases it. The bench runs compare-stop well past the first match and checks that the pin level and the counter no longer move. It then passes through mode 000 for one clock, re-enters, and checks that status is clear and the period starts over. A behavioural model compares against every clock in all modes, including the pulse-capture path, where the run bit has to be ignored.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MD_OFF     = 3'd0,
        MD_CAPTURE = 3'd1,
        MD_COMPARE = 3'd2,
        MD_PWM     = 3'd3,
        MD_TIMER   = 3'd4,
        MD_GPIO    = 3'd5
    } tmr_mode_e;

    typedef struct packed {
        logic en;
        logic val;
    } pin_drv_t;

    // A driven 1 becomes high impedance under open-drain emulation.
    function automatic pin_drv_t od_filter(pin_drv_t d, logic od);
        pin_drv_t r;
        r.en  = d.en & ~(od & d.val);
        r.val = r.en & d.val;
        return r;
    endfunction

    function automatic logic is_timeout_mode(tmr_mode_e m);
        return (m == MD_COMPARE) || (m == MD_TIMER);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;

    // At-or-above so that a lowered limit cannot strand the count.
    assign tick = run && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_mode_e        mode,
    input  logic             cont,
    input  logic             pulse_cap,
    input  logic             tick,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] lim,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             status_o,
    output logic             oc_lvl_o,
    output logic             halted_o
);

    logic [CNT_W-1:0] cnt_q, cap_q, cnt_inc;
    logic             status_q, oc_q, halted_q, pin_q;
    logic             rise, fall, at_lim;

    assign rise    = pin_in & ~pin_q;
    assign fall    = ~pin_in & pin_q;
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign at_lim  = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst) pin_q <= 1'b0;
        else     pin_q <= pin_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            cap_q    <= '0;
            status_q <= 1'b0;
            oc_q     <= 1'b0;
            halted_q <= 1'b0;
        end else if (mode == MD_OFF) begin
            cnt_q    <= '0;
            status_q <= 1'b0;
            oc_q     <= 1'b0;
            halted_q <= 1'b0;
        end else begin
            case (mode)
                MD_CAPTURE: begin
                    if (pulse_cap) begin
                        if (rise) begin
                            cnt_q <= '0;
                        end else if (fall) begin
                            cap_q    <= cnt_q;
                            status_q <= 1'b1;
                            cnt_q    <= '0;
                        end else if (tick) begin
                            cnt_q <= cnt_inc;
                        end
                    end else if (rise) begin
                        cap_q    <= cnt_q;
                        status_q <= 1'b1;
                        if (!cont)     cnt_q <= '0;
                        else if (tick) cnt_q <= cnt_inc;
                    end else if (tick) begin
                        cnt_q <= cnt_inc;
                    end
                end
                MD_COMPARE, MD_TIMER: begin
                    if (tick) begin
                        if (at_lim) begin
                            cnt_q    <= '0;
                            status_q <= 1'b1;
                            if (!cont) halted_q <= 1'b1;
                            if (mode == MD_COMPARE) oc_q <= ~oc_q;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end
                end
                MD_PWM: begin
                    if (tick) begin
                        if (at_lim) begin
                            cnt_q    <= '0;
                            status_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign cnt_o    = cnt_q;
    assign cap_o    = cap_q;
    assign status_o = status_q;
    assign oc_lvl_o = oc_q;
    assign halted_o = halted_q;

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_OFF) |=> (cnt_q == '0 && !status_q && !halted_q && !oc_q)); // R1

    AST_CNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (mode != MD_OFF && !tick && !rise && !fall) |=> $stable(cnt_q)); // R2

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (halted_q && is_timeout_mode(mode)) |=> (halted_q && $stable(cnt_q) && $stable(oc_q))); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_q && mode != MD_OFF) |=> status_q); // R12

endmodule

// File: rtl/tmr_pin_drv.sv
module tmr_pin_drv
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  tmr_mode_e        mode,
    input  logic [1:0]       gpio_sel,
    input  logic             od,
    input  logic             oc_lvl,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] width,
    output logic             pin_o,
    output logic             pin_oe
);

    pin_drv_t raw, fin;

    always_comb begin
        raw = '0;
        case (mode)
            MD_COMPARE: raw = '{en: 1'b1, val: oc_lvl};
            MD_PWM:     raw = '{en: 1'b1, val: (cnt < width)};
            MD_TIMER, MD_GPIO: raw = '{en: gpio_sel[1], val: gpio_sel[1] & gpio_sel[0]};
            default:    raw = '0;
        endcase
        fin = od_filter(raw, od);
    end

    assign pin_o  = fin.val;
    assign pin_oe = fin.en;

    always_comb begin
        if (od) begin
            AST_OD_NEVER_HIGH: assert (!(pin_oe && pin_o)); // R10
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 16,
    localparam int DATA_W = (CNT_W > PRE_W) ? CNT_W : PRE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic              cont_i,
    input  logic              pulse_cap_i,
    input  logic              open_drain_i,
    input  logic              irq_en_i,
    input  logic [1:0]        gpio_sel_i,
    input  logic              wr_prescale_i,
    input  logic              wr_limit_i,
    input  logic              wr_width_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pin_i,
    output logic              pin_o,
    output logic              pin_oe_o,
    output logic [CNT_W-1:0]  capture_o,
    output logic              status_o,
    output logic              irq_o
);

    tmr_mode_e        mode;
    logic [PRE_W-1:0] prescale_q;
    logic [CNT_W-1:0] limit_q, width_q, cnt;
    logic             tick, halted, oc_lvl, status;

    assign mode = tmr_mode_e'(mode_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prescale_q <= '0;
            limit_q    <= '0;
            width_q    <= '0;
        end else begin
            if (wr_prescale_i) prescale_q <= wdata_i[PRE_W-1:0];
            if (wr_limit_i)    limit_q    <= wdata_i[CNT_W-1:0];
            if (wr_width_i)    width_q    <= wdata_i[CNT_W-1:0];
        end
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (mode == MD_OFF),
        .run   ((mode != MD_OFF) && !halted),
        .limit (prescale_q),
        .tick  (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .cont      (cont_i),
        .pulse_cap (pulse_cap_i),
        .tick      (tick),
        .pin_in    (pin_i),
        .lim       (limit_q),
        .cnt_o     (cnt),
        .cap_o     (capture_o),
        .status_o  (status),
        .oc_lvl_o  (oc_lvl),
        .halted_o  (halted)
    );

    tmr_pin_drv #(.CNT_W(CNT_W)) u_pin (
        .mode     (mode),
        .gpio_sel (gpio_sel_i),
        .od       (open_drain_i),
        .oc_lvl   (oc_lvl),
        .cnt      (cnt),
        .width    (width_q),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe_o)
    );

    assign status_o = status;
    assign irq_o    = status & irq_en_i;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o); // R12

endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic        cont = 1'b0, pulse = 1'b0, od = 1'b0, ien = 1'b0;
    logic [1:0]  gsel = 2'b00;
    logic        wr_ps = 1'b0, wr_lim = 1'b0, wr_wid = 1'b0;
    logic [15:0] wdata = 16'd0;
    logic        pin_i = 1'b0;
    logic        pin_o, pin_oe;
    logic [15:0] cap;
    logic        status, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tmr_channel uut (
        .clk(clk), .rst(rst), .mode_i(mode), .cont_i(cont), .pulse_cap_i(pulse),
        .open_drain_i(od), .irq_en_i(ien), .gpio_sel_i(gsel),
        .wr_prescale_i(wr_ps), .wr_limit_i(wr_lim), .wr_width_i(wr_wid),
        .wdata_i(wdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe),
        .capture_o(cap), .status_o(status), .irq_o(irq)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int m_pre = 0, m_cnt = 0, m_stat = 0, m_halt = 0, m_oc = 0, m_cap = 0, m_pinq = 0;
    int m_ps = 0, m_lim = 0, m_wid = 0;

    always @(posedge clk) begin
        int tk, rs, fl, rn;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_stat = 0; m_halt = 0; m_oc = 0; m_cap = 0;
            m_pinq = 0; m_ps = 0; m_lim = 0; m_wid = 0;
        end else begin
            rs = (pin_i && !m_pinq) ? 1 : 0;
            fl = (!pin_i && m_pinq) ? 1 : 0;
            rn = (mode != 3'd0 && m_halt == 0) ? 1 : 0;
            tk = (rn != 0 && m_pre >= m_ps) ? 1 : 0;
            if (mode == 3'd0) begin
                m_pre = 0; m_cnt = 0; m_stat = 0; m_halt = 0; m_oc = 0;
            end else begin
                if (rn != 0) m_pre = (tk != 0) ? 0 : m_pre + 1;
                if (mode == 3'd1) begin
                    if (pulse) begin
                        if (rs != 0) m_cnt = 0;
                        else if (fl != 0) begin m_cap = m_cnt; m_stat = 1; m_cnt = 0; end
                        else if (tk != 0) m_cnt = (m_cnt + 1) % 65536;
                    end else if (rs != 0) begin
                        m_cap = m_cnt; m_stat = 1;
                        if (!cont) m_cnt = 0;
                        else if (tk != 0) m_cnt = (m_cnt + 1) % 65536;
                    end else if (tk != 0) m_cnt = (m_cnt + 1) % 65536;
                end else if (mode == 3'd2 || mode == 3'd4) begin
                    if (tk != 0) begin
                        if (m_cnt >= m_lim) begin
                            m_cnt = 0; m_stat = 1;
                            if (!cont) m_halt = 1;
                            if (mode == 3'd2) m_oc = (m_oc != 0) ? 0 : 1;
                        end else m_cnt = m_cnt + 1;
                    end
                end else if (mode == 3'd3) begin
                    if (tk != 0) begin
                        if (m_cnt >= m_lim) begin m_cnt = 0; m_stat = 1; end
                        else m_cnt = m_cnt + 1;
                    end
                end
            end
            if (wr_ps)  m_ps  = int'(wdata);
            if (wr_lim) m_lim = int'(wdata);
            if (wr_wid) m_wid = int'(wdata);
            m_pinq = pin_i ? 1 : 0;
        end
    end

    function automatic string mode_tag();
        if (od) return "R10";
        case (mode)
            3'd1: return pulse ? "R5" : (cont ? "R4" : "R3");
            3'd2: return cont ? "R7" : "R6";
            3'd3: return "R8";
            3'd4: return "R9";
            3'd5: return "R11";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_cmp();
        int en, val, eo, ex;
        en = 0; val = 0;
        case (mode)
            3'd2: begin en = 1; val = m_oc; end
            3'd3: begin en = 1; val = (m_cnt < m_wid) ? 1 : 0; end
            3'd4, 3'd5: begin en = gsel[1] ? 1 : 0; val = (gsel == 2'b11) ? 1 : 0; end
            default: ;
        endcase
        if (od && val != 0) en = 0;
        eo = (en != 0) ? val : 0;
        ex = {m_cap[15:0], m_stat[0], (m_stat != 0 && ien) ? 1'b1 : 1'b0, en[0], eo[0]};
        chk(ex == int'({cap, status, irq, pin_oe, pin_o}), mode_tag(),
            int'({cap, status, irq, pin_oe, pin_o}), ex);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_cmp();
        end
    endtask

    task automatic wr(input int which, input int v);
        wdata = 16'(v);
        wr_ps = (which == 0); wr_lim = (which == 1); wr_wid = (which == 2);
        step(1);
        wr_ps = 1'b0; wr_lim = 1'b0; wr_wid = 1'b0;
    endtask

    task automatic go_idle();
        mode = 3'd0; pin_i = 1'b0;
        step(2);
    endtask

    initial begin
        int c3, c4, hi, oe_cnt, tog, prev;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1);
        chk(!pin_oe && !status && !irq, "R1", int'({pin_oe, status, irq}), 0);

        // R3 capture, stop
        ien = 1'b1; mode = 3'd1; cont = 1'b0;
        for (int k = 0; k < 4; k++) begin pin_i = 1'b1; step(3); pin_i = 1'b0; step(3); end
        chk(cap == 16'd5, "R3", cap, 5);
        chk(status && irq, "R12", int'({status, irq}), 3);
        go_idle();
        chk(!status && !irq, "R1", int'({status, irq}), 0);

        // R4 capture, continuous
        mode = 3'd1; cont = 1'b1;
        c3 = 0; c4 = 0;
        for (int k = 0; k < 4; k++) begin
            pin_i = 1'b1; step(3);
            if (k == 2) c3 = int'(cap);
            if (k == 3) c4 = int'(cap);
            pin_i = 1'b0; step(3);
        end
        chk(c4 - c3 == 6, "R4", c4 - c3, 6);
        go_idle();

        // R5 pulse capture, run bit ignored
        pulse = 1'b1; mode = 3'd1; cont = 1'b1;
        for (int k = 0; k < 3; k++) begin pin_i = 1'b1; step(4); pin_i = 1'b0; step(4); end
        chk(cap == 16'd3, "R5", cap, 3);
        go_idle();
        pulse = 1'b0;

        // R6 compare, stop, restart via idle
        wr(1, 3);
        mode = 3'd2; cont = 1'b0;
        step(20);
        chk(status && pin_oe && pin_o, "R6", int'({status, pin_oe, pin_o}), 7);
        step(20);
        chk(pin_o == 1'b1, "R6", pin_o, 1);
        mode = 3'd0; step(1);
        mode = 3'd2; step(2);
        chk(!status && !pin_o, "R6", int'({status, pin_o}), 0);
        go_idle();

        // R7 compare, continuous
        mode = 3'd2; cont = 1'b1;
        step(1);
        prev = int'(pin_o); tog = 0;
        for (int i = 0; i < 16; i++) begin
            step(1);
            if (int'(pin_o) != prev) tog++;
            prev = int'(pin_o);
        end
        chk(tog == 4, "R7", tog, 4);
        go_idle();

        // R8 / R2 PWM with prescale 1
        wr(0, 1); wr(1, 4); wr(2, 2);
        mode = 3'd3; cont = 1'b0;
        step(3);
        hi = 0;
        for (int i = 0; i < 20; i++) begin step(1); if (pin_oe && pin_o) hi++; end
        chk(hi == 8, "R2", hi, 8);
        cont = 1'b1;
        hi = 0;
        for (int i = 0; i < 20; i++) begin step(1); if (pin_oe && pin_o) hi++; end
        chk(hi == 8, "R8", hi, 8);
        chk(status == 1'b1, "R8", status, 1);

        // R10 open drain on PWM
        od = 1'b1; hi = 0; oe_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (pin_o) hi++;
            if (pin_oe) oe_cnt++;
        end
        chk(hi == 0 && oe_cnt == 12, "R10", oe_cnt, 12);
        od = 1'b0;
        go_idle();

        // R9 timer, GPIO alongside
        wr(0, 0); wr(1, 5);
        mode = 3'd4; cont = 1'b0; gsel = 2'b11;
        step(1);
        chk(pin_oe && pin_o, "R11", int'({pin_oe, pin_o}), 3);
        step(10);
        chk(status == 1'b1, "R9", status, 1);
        step(30);
        chk(status == 1'b1, "R12", status, 1);
        ien = 1'b0; step(1);
        chk(!irq, "R12", irq, 0);
        ien = 1'b1;
        gsel = 2'b10; step(1);
        chk(pin_oe && !pin_o, "R11", int'({pin_oe, pin_o}), 2);
        gsel = 2'b01; step(1);
        chk(!pin_oe, "R11", pin_oe, 0);
        od = 1'b1; gsel = 2'b11; step(1);
        chk(!pin_oe && !pin_o, "R10", int'({pin_oe, pin_o}), 0);
        od = 1'b0;
        mode = 3'd0; step(1);
        chk(!status, "R9", status, 0);
        mode = 3'd4; cont = 1'b1; step(30);
        chk(status == 1'b1, "R9", status, 1);
        go_idle();

        // R11 GPIO-only mode
        mode = 3'd5; gsel = 2'b10; step(2);
        chk(pin_oe && !pin_o, "R11", int'({pin_oe, pin_o}), 2);
        go_idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule